// File: doc/BRIEF.md
# I2C Slave Status and Interrupt Logic

This block holds the status flags that software sees for an I2C slave peripheral, and it drives the interrupt request line. A serial engine sends one-cycle event strobes. The engine reports a start condition, a line pulled low, a stop condition, an address match together with the transfer direction, a received byte ready for loading, and a transmitted byte. From these strobes the block tracks the bus occupancy and slave selection in a three-state machine. It also keeps three sticky flags: receive-ready, transmit-empty and terminate-detect. Each sticky flag has its own clear path. Reading the receive data word clears receive-ready. Writing the transmit data word clears transmit-empty. Writing a one to bit 0 of the event word clears terminate-detect.

The bus machine has three states. In `BS_FREE` the bus is idle. `BS_FREE` moves to `BS_BUSY` on a start strobe or a line-low strobe. `BS_BUSY` means the bus is occupied by some transfer. `BS_BUSY` moves to `BS_SEL` on an address match. `BS_SEL` means this slave is addressed. A stop strobe returns the machine to `BS_FREE` from any state. A repeated start moves `BS_SEL` back to `BS_BUSY`. When the machine leaves `BS_SEL` on a stop or a repeated start, terminate-detect is set. When several strobes land in the same cycle, stop wins over start, and start wins over address match.

The register port uses word addresses and combinational read data. The interrupt request is a level. It is the OR of each pending sticky flag masked by its own enable input.

Top module: `i2c_slv_stat_irq`

## Requirements
- R1: After reset, every flag is 0, the status word and the event word read 0, and irq is low.
- R2: A read at address 0 returns the status word. The word holds receive-ready at bit 4, transmit-empty at bit 3, busy at bit 2, selected at bit 1, and direction at bit 0 (1 means the slave transmits). Bits 15 to 5 read as 0.
- R3: Busy becomes 1 on a start strobe or a line-low strobe, and returns to 0 in the cycle after a stop strobe.
- R4: An address match is honoured only while busy and not selected. It sets selected and captures the direction strobe value. A stop or a repeated start clears selected and direction, and a repeated start leaves busy at 1. An address match while the bus is free is ignored.
- R5: Terminate-detect is set when a stop or a repeated start arrives while selected, and is read at bit 0 of address 1. It stays set until a write to address 1 with bit 0 equal to 1. A write of 0 does not clear it, and a stop while busy but not selected does not set it.
- R6: Receive-ready is set by a receive-load strobe and is cleared by a read at address 2. That read returns the receive byte in bits 7 to 0.
- R7: Transmit-empty is set by a transmit-sent strobe and is cleared by a write at address 3.
- R8: When a set strobe and a software clear of the same flag occur in the same cycle, the flag ends up set.
- R9: irq equals (receive-ready AND ien_rx) OR (transmit-empty AND ien_tx) OR (terminate-detect AND ien_bus). It is a level that changes in the same cycle as its inputs.
- R10: Writes to address 0 change no flag, and reads of address 0 or 1 clear nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start | input | 1 | Start or repeated-start strobe |
| ev_line_low | input | 1 | SCL or SDA seen low strobe |
| ev_stop | input | 1 | Stop condition strobe |
| ev_addr_match | input | 1 | Own address received strobe |
| ev_dir | input | 1 | Direction bit, valid with ev_addr_match |
| ev_rx_load | input | 1 | Received byte loaded strobe |
| ev_tx_sent | input | 1 | Transmit byte sent strobe |
| rx_byte | input | 8 | Current received byte |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, 0 when rd_en is low |
| ien_rx | input | 1 | Receive-ready interrupt enable |
| ien_tx | input | 1 | Transmit-empty interrupt enable |
| ien_bus | input | 1 | Terminate-detect interrupt enable |
| irq | output | 1 | Level interrupt request |

## Verification
The bench sweeps all eight combinations of pending flags against all eight enable patterns. A wrong mask or a wrong OR shows up there as irq high with its source masked, or as irq low while an enabled flag is pending. It drives a set strobe into the same cycle as each flag's software clear. A design that let the clear win would drop an event, so the flag would read 0. It also sends an address match while the bus is free and a stop while busy but unselected. A machine that took a wrong transition would report selected, or would raise terminate-detect where it must stay 0. Writes of 0 to the event word and writes to the status word check that write-one-to-clear and the read-only bits are decoded correctly.

// File: rtl/i2cs_stat_pkg.sv
package i2cs_stat_pkg;
    typedef enum logic [1:0] {
        BS_FREE = 2'd0,
        BS_BUSY = 2'd1,
        BS_SEL  = 2'd2
    } bus_st_e;

    localparam int REG_STAT = 0;
    localparam int REG_EVT  = 1;
    localparam int REG_RXD  = 2;
    localparam int REG_TXD  = 3;

    localparam int N_FLAG = 3;
    localparam int F_RX   = 0;
    localparam int F_TX   = 1;
    localparam int F_TERM = 2;
endpackage

// File: rtl/i2cs_bus_fsm.sv
module i2cs_bus_fsm
    import i2cs_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_start,
    input  logic ev_line_low,
    input  logic ev_stop,
    input  logic ev_addr_match,
    input  logic ev_dir,
    output logic busy,
    output logic selected,
    output logic dir,
    output logic term_evt
);
    bus_st_e st_q, st_d;
    logic    dir_q;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= BS_FREE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BS_FREE: if (!ev_stop && (ev_start || ev_line_low)) st_d = BS_BUSY;
            BS_BUSY: begin
                if (ev_stop)            st_d = BS_FREE;
                else if (ev_start)      st_d = BS_BUSY;
                else if (ev_addr_match) st_d = BS_SEL;
            end
            BS_SEL: begin
                if (ev_stop)       st_d = BS_FREE;
                else if (ev_start) st_d = BS_BUSY;
            end
            default: st_d = BS_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            dir_q <= 1'b0;
        else if (st_q == BS_BUSY && st_d == BS_SEL)
            dir_q <= ev_dir;
        else if (st_q == BS_SEL && st_d != BS_SEL)
            dir_q <= 1'b0;
    end

    always_comb begin
        busy     = (st_q != BS_FREE);
        selected = (st_q == BS_SEL);
        dir      = dir_q;
        term_evt = (st_q == BS_SEL) && (ev_stop || ev_start);
    end
endmodule

// File: rtl/i2cs_flag_bank.sv
module i2cs_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic f_q;
        always_ff @(posedge clk) begin
            if (!rst_n)      f_q <= 1'b0;
            else if (set[i]) f_q <= 1'b1;
            else if (clr[i]) f_q <= 1'b0;
        end
        assign q[i] = f_q;
    end
endmodule

// File: rtl/i2cs_reg_port.sv
module i2cs_reg_port
    import i2cs_stat_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 16,
    parameter int RXB_W  = 8
) (
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [RXB_W-1:0]  rx_byte,
    input  logic [N_FLAG-1:0] flags,
    input  logic              busy,
    input  logic              selected,
    input  logic              dir,
    output logic [N_FLAG-1:0] clr,
    output logic [DATA_W-1:0] rdata
);
    localparam int STAT_W = 5;

    logic [STAT_W-1:0] stat;
    logic              unused_wdata;

    assign unused_wdata = ^wdata[DATA_W-1:1];
    assign stat = {flags[F_RX], flags[F_TX], busy, selected, dir};

    always_comb begin
        clr         = '0;
        clr[F_RX]   = rd_en && (addr == ADDR_W'(REG_RXD));
        clr[F_TX]   = wr_en && (addr == ADDR_W'(REG_TXD));
        clr[F_TERM] = wr_en && (addr == ADDR_W'(REG_EVT)) && wdata[0];
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (addr)
                ADDR_W'(REG_STAT): rdata = DATA_W'(stat);
                ADDR_W'(REG_EVT):  rdata = DATA_W'(flags[F_TERM]);
                ADDR_W'(REG_RXD):  rdata = DATA_W'(rx_byte);
                default:           rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/i2c_slv_stat_irq.sv
module i2c_slv_stat_irq
    import i2cs_stat_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 16,
    parameter int RXB_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_start,
    input  logic              ev_line_low,
    input  logic              ev_stop,
    input  logic              ev_addr_match,
    input  logic              ev_dir,
    input  logic              ev_rx_load,
    input  logic              ev_tx_sent,
    input  logic [RXB_W-1:0]  rx_byte,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              ien_rx,
    input  logic              ien_tx,
    input  logic              ien_bus,
    output logic              irq
);
    logic              busy_q, sel_q, dir_q, term_evt;
    logic [N_FLAG-1:0] fl_set, fl_clr, fl_q, fl_en;
    logic              rx_rdy_q, tx_emp_q, stop_q;

    i2cs_bus_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .ev_start      (ev_start),
        .ev_line_low   (ev_line_low),
        .ev_stop       (ev_stop),
        .ev_addr_match (ev_addr_match),
        .ev_dir        (ev_dir),
        .busy          (busy_q),
        .selected      (sel_q),
        .dir           (dir_q),
        .term_evt      (term_evt)
    );

    always_comb begin
        fl_set         = '0;
        fl_set[F_RX]   = ev_rx_load;
        fl_set[F_TX]   = ev_tx_sent;
        fl_set[F_TERM] = term_evt;
        fl_en          = '0;
        fl_en[F_RX]    = ien_rx;
        fl_en[F_TX]    = ien_tx;
        fl_en[F_TERM]  = ien_bus;
    end

    i2cs_flag_bank #(.N(N_FLAG)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (fl_set),
        .clr   (fl_clr),
        .q     (fl_q)
    );

    i2cs_reg_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RXB_W(RXB_W)) u_port (
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rx_byte  (rx_byte),
        .flags    (fl_q),
        .busy     (busy_q),
        .selected (sel_q),
        .dir      (dir_q),
        .clr      (fl_clr),
        .rdata    (rdata)
    );

    assign rx_rdy_q = fl_q[F_RX];
    assign tx_emp_q = fl_q[F_TX];
    assign stop_q   = fl_q[F_TERM];
    assign irq      = |(fl_q & fl_en);
endmodule

// File: rtl/i2cs_stat_chk.sv
module i2cs_stat_chk
    import i2cs_stat_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_start,
    input logic              ev_stop,
    input logic              ev_rx_load,
    input logic              ev_tx_sent,
    input logic              rd_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic              ien_rx,
    input logic              ien_tx,
    input logic              ien_bus,
    input logic              irq,
    input logic              rx_rdy_q,
    input logic              tx_emp_q,
    input logic              stop_q,
    input logic              busy_q,
    input logic              sel_q
);
    p_stat_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(REG_STAT)) |-> (rdata[DATA_W-1:5] == '0));

    p_busy_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> !busy_q);

    p_sel_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q |-> busy_q);

    p_term_origin_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_q) |-> $past(sel_q && (ev_stop || ev_start)));

    p_term_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q && !(wr_en && addr == ADDR_W'(REG_EVT))) |=> stop_q);

    p_rx_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(REG_RXD) && !ev_rx_load) |=> !rx_rdy_q);

    p_tx_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(REG_TXD) && !ev_tx_sent) |=> !tx_emp_q);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx_load && ev_tx_sent) |=> (rx_rdy_q && tx_emp_q));

    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ien_rx && !ien_tx && !ien_bus) |-> !irq);

    p_irq_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rdy_q && ien_rx) |-> irq);

    p_stat_ro_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(REG_STAT) && !ev_rx_load && !ev_tx_sent)
            |=> ($stable(rx_rdy_q) && $stable(tx_emp_q)));
endmodule

bind i2c_slv_stat_irq i2cs_stat_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_start   (ev_start),
    .ev_stop    (ev_stop),
    .ev_rx_load (ev_rx_load),
    .ev_tx_sent (ev_tx_sent),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .addr       (addr),
    .rdata      (rdata),
    .ien_rx     (ien_rx),
    .ien_tx     (ien_tx),
    .ien_bus    (ien_bus),
    .irq        (irq),
    .rx_rdy_q   (rx_rdy_q),
    .tx_emp_q   (tx_emp_q),
    .stop_q     (stop_q),
    .busy_q     (busy_q),
    .sel_q      (sel_q)
);

// File: tb/sim_i2c_slv_stat_irq.sv
module sim_i2c_slv_stat_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_start = 0, ev_line_low = 0, ev_stop = 0, ev_addr_match = 0, ev_dir = 0;
    logic        ev_rx_load = 0, ev_tx_sent = 0;
    logic [7:0]  rx_byte = 8'h00;
    logic        rd_en = 0, wr_en = 0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        ien_rx = 0, ien_tx = 0, ien_bus = 0;
    logic        irq;

    int          n_chk = 0;
    int          n_err = 0;
    logic [15:0] rv;
    bit          done = 0;

    always #2 clk = ~clk;

    i2c_slv_stat_irq u0 (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_line_low(ev_line_low),
        .ev_stop(ev_stop), .ev_addr_match(ev_addr_match), .ev_dir(ev_dir),
        .ev_rx_load(ev_rx_load), .ev_tx_sent(ev_tx_sent), .rx_byte(rx_byte),
        .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .ien_rx(ien_rx), .ien_tx(ien_tx), .ien_bus(ien_bus), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // ev bits: 6 line_low, 5 start, 4 stop, 3 addr_match, 2 dir, 1 rx_load, 0 tx_sent
    task automatic pulse(input logic [6:0] ev);
        {ev_line_low, ev_start, ev_stop, ev_addr_match, ev_dir, ev_rx_load, ev_tx_sent} = ev;
        @(posedge clk); #1;
        {ev_line_low, ev_start, ev_stop, ev_addr_match, ev_dir, ev_rx_load, ev_tx_sent} = '0;
    endtask

    task automatic rd(input logic [1:0] a);
        rd_en = 1; addr = a; #1;
        rv = rdata;
        @(posedge clk); #1;
        rd_en = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 0; wdata = 0;
    endtask

    task automatic set_term();
        pulse(7'b0100000);
        pulse(7'b0001000);
        pulse(7'b0010000);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        rd(2'd0); check("R1 status", rv, 16'h0000);
        rd(2'd1); check("R1 event", rv, 16'h0000);
        check("R1 irq", {15'b0, irq}, 16'h0000);

        // R3 busy tracking
        pulse(7'b0100000); rd(2'd0); check("R3 busy on start", rv, 16'h0004);
        pulse(7'b0010000); rd(2'd0); check("R3 free on stop", rv, 16'h0000);
        pulse(7'b1000000); rd(2'd0); check("R3 busy on line low", rv, 16'h0004);
        pulse(7'b0010000);

        // R4 address match while free is ignored
        pulse(7'b0001100); rd(2'd0); check("R4 match while free", rv, 16'h0000);

        // R4 selection with direction, R5 repeated start
        pulse(7'b0100000); pulse(7'b0001100);
        rd(2'd0); check("R2 R4 selected transmit", rv, 16'h0007);
        rd(2'd1); check("R5 event clear while selected", rv, 16'h0000);
        pulse(7'b0100000);
        rd(2'd0); check("R4 repeated start keeps busy", rv, 16'h0004);
        rd(2'd1); check("R5 set on repeated start", rv, 16'h0001);
        ien_bus = 1; #1;
        check("R9 bus irq", {15'b0, irq}, 16'h0001);
        wr(2'd1, 16'h0000); rd(2'd1); check("R5 write 0 keeps", rv, 16'h0001);
        wr(2'd1, 16'h0001); rd(2'd1); check("R5 w1c", rv, 16'h0000);
        check("R9 irq drops", {15'b0, irq}, 16'h0000);
        pulse(7'b0001000); rd(2'd0); check("R4 selected receive", rv, 16'h0006);
        pulse(7'b0010000);
        rd(2'd0); check("R4 stop clears", rv, 16'h0000);
        rd(2'd1); check("R5 set on stop", rv, 16'h0001);
        wr(2'd1, 16'h0001);
        pulse(7'b0100000); pulse(7'b0010000);
        rd(2'd1); check("R5 unselected stop", rv, 16'h0000);
        ien_bus = 0;

        // R6 receive path, R10 reads
        rx_byte = 8'hA5;
        pulse(7'b0000010); rd(2'd0); check("R6 rx ready", rv, 16'h0010);
        rd(2'd1); rd(2'd0); check("R10 reads keep rx", rv, 16'h0010);
        rd(2'd2); check("R6 rx byte", rv, 16'h00A5);
        rd(2'd0); check("R6 rx cleared", rv, 16'h0000);

        // R7 transmit path, R10 write to status
        pulse(7'b0000001); rd(2'd0); check("R7 tx empty", rv, 16'h0008);
        wr(2'd0, 16'hFFFF); rd(2'd0); check("R10 status write ignored", rv, 16'h0008);
        wr(2'd3, 16'h0055); rd(2'd0); check("R7 tx cleared", rv, 16'h0000);

        // R8 set wins
        rd_en = 1; addr = 2'd2; ev_rx_load = 1;
        @(posedge clk); #1; rd_en = 0; ev_rx_load = 0;
        rd(2'd0); check("R8 rx set wins", rv, 16'h0010);
        rd(2'd2);
        wr_en = 1; addr = 2'd3; ev_tx_sent = 1;
        @(posedge clk); #1; wr_en = 0; ev_tx_sent = 0;
        rd(2'd0); check("R8 tx set wins", rv, 16'h0008);
        wr(2'd3, 16'h0);
        set_term();
        pulse(7'b0100000); pulse(7'b0001000);
        wr_en = 1; addr = 2'd1; wdata = 16'h0001; ev_stop = 1;
        @(posedge clk); #1; wr_en = 0; wdata = 0; ev_stop = 0;
        rd(2'd1); check("R8 term set wins", rv, 16'h0001);
        wr(2'd1, 16'h0001);

        // R9 sweep of pending flags vs enables
        for (int p = 0; p < 8; p++) begin
            if (p[0]) pulse(7'b0000010);
            if (p[1]) pulse(7'b0000001);
            if (p[2]) set_term();
            for (int e = 0; e < 8; e++) begin
                {ien_bus, ien_tx, ien_rx} = e[2:0]; #1;
                check("R9 irq sweep", {15'b0, irq}, {15'b0, |(p[2:0] & e[2:0])});
            end
            {ien_bus, ien_tx, ien_rx} = 3'b000;
            rd(2'd2); wr(2'd3, 16'h0); wr(2'd1, 16'h0001);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule